// File: doc/BRIEF.md
# Supply supervisor reset controller

This block turns digitized supply comparator results into a clean system reset and two auxiliary supply alarms. The main reset is raised while the main supply sits under its trip point or while a push-button manual reset is pressed. It is released only after a hold time, chosen by a 2-bit select, has run out with both conditions quiet. The push-button input is asynchronous and bouncy, so it is synchronized and debounced inside the block before it takes effect.

Two auxiliary channels each report when their supply has risen above its own trip point. Each channel also keeps a sticky status flag. Software arms the flag by writing 1 after start-up, and the channel clears it to 0 as soon as its alarm condition is seen. Software can then tell that a trip happened even if the alarm has gone away again.

All comparator inputs are taken as already synchronous to `clk`. Only the manual-reset input is treated as asynchronous.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is 1 and `aux_alarm_o` and `aux_status_o` are all 0. After `rst_n` is released with no fault present, `sys_rst_o` falls exactly HOLD3 clock edges later.
- R2: A cycle in which `main_below_i` is 1 makes `sys_rst_o` 1 after the next clock edge. It stays 1 for as long as `main_below_i` stays 1.
- R3: The hold select in force on the last edge that sees the fault picks the release delay: 00 gives HOLD0, 01 gives HOLD1, 10 gives HOLD2 and 11 gives HOLD3 cycles (defaults 50, 100, 200 and 400). `sys_rst_o` falls on exactly the Nth edge after that last fault edge, where N is the selected count.
- R4: A new fault during the hold countdown reloads it. The full selected hold time is counted again from the end of the new fault.
- R5: `mrst_raw_i` passes through a two-flop synchronizer and is then debounced. A new level is taken only after DB_CYCLES consecutive sampled cycles at that level. An accepted high level forces `sys_rst_o` to 1, whatever the state of `main_below_i`.
- R6: A manual-reset pulse that lasts fewer than DB_CYCLES cycles is ignored and leaves `sys_rst_o` at 0.
- R7: After a debounced manual-reset release, `sys_rst_o` stays 1 for the selected hold time. It falls DB_CYCLES + 2 + HOLD edges after the raw input returns low.
- R8: Bit i of `aux_alarm_o` equals bit i of `aux_above_i` as sampled on the previous clock edge.
- R9: On an edge with `arm_we_i` = 1, bit i of `aux_status_o` takes bit i of `arm_data_i`. On any edge where bit i of `aux_above_i` is 1, status bit i becomes 0, and this clear wins over a simultaneous write.
- R10: With no write and no trip, a status bit keeps its value. It never goes from 0 to 1 without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| main_below_i | input | 1 | Main supply is under its trip point |
| aux_above_i | input | NAUX | Auxiliary supply i is over its trip point |
| mrst_raw_i | input | 1 | Raw push-button manual reset, active high, asynchronous |
| hold_sel_i | input | 2 | Hold-time select |
| arm_we_i | input | 1 | Write strobe for the status flags |
| arm_data_i | input | NAUX | Value written to the status flags |
| sys_rst_o | output | 1 | Main supervisory reset, active high |
| aux_alarm_o | output | NAUX | Auxiliary over-threshold alarms |
| aux_status_o | output | NAUX | Sticky status flags, cleared by trips |

## Verification
Alarm and status outputs are due one edge after their inputs. The main reset rises one edge after a supply fault, and DB_CYCLES + 3 edges after a raw manual press. Release comes HOLD edges after the last fault edge, or DB_CYCLES + 2 + HOLD edges after a manual release. The bench drives inputs 1 ns after each rising edge. It advances a behavioural model on that same edge and compares every output just after the edge. Directed checks then count edges until the release and compare the count with the selected hold value.

// File: rtl/supsup_pkg.sv
package supsup_pkg;

  typedef enum logic [1:0] {
    HOLD_SHORT = 2'b00,
    HOLD_MED   = 2'b01,
    HOLD_LONG  = 2'b10,
    HOLD_MAX   = 2'b11
  } hold_sel_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mrst_debounce.sv
module mrst_debounce #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STABLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_lvl;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   level_q, level_d;
  logic                   cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    if (sync_lvl == level_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
      cnt_d   = '0;
      level_d = sync_lvl;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = (sync_lvl != level_q) || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/hold_timer.sv
module hold_timer
  import supsup_pkg::*;
#(
  parameter int unsigned HOLD0 = 50,
  parameter int unsigned HOLD1 = 100,
  parameter int unsigned HOLD2 = 200,
  parameter int unsigned HOLD3 = 400,
  parameter int unsigned CW    = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_i,
  input  logic [1:0] sel_i,
  output logic       active_o
);
  logic [CW-1:0] left_q, left_d, load_val;
  logic          act_q, act_d;
  logic          upd_en;

  always_comb begin
    unique case (hold_sel_e'(sel_i))
      HOLD_SHORT: load_val = CW'(HOLD0);
      HOLD_MED:   load_val = CW'(HOLD1);
      HOLD_LONG:  load_val = CW'(HOLD2);
      default:    load_val = CW'(HOLD3);
    endcase
  end

  always_comb begin
    left_d = left_q;
    act_d  = act_q;
    if (fault_i) begin
      left_d = load_val;
      act_d  = 1'b1;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
      act_d  = (left_q != CW'(1));
    end else begin
      act_d = 1'b0;
    end
  end

  assign upd_en = fault_i || (left_q != '0) || act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= CW'(HOLD3);
      act_q  <= 1'b1;
    end else if (upd_en) begin
      left_q <= left_d;
      act_q  <= act_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/aux_channel.sv
module aux_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic above_i,
  input  logic arm_we_i,
  input  logic arm_bit_i,
  output logic alarm_o,
  output logic status_o
);
  logic alarm_q;
  logic stat_q, stat_d;
  logic stat_en;

  always_comb begin
    stat_d = arm_we_i ? arm_bit_i : stat_q;
    if (above_i) stat_d = 1'b0;
  end

  assign stat_en = arm_we_i || above_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= above_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign alarm_o  = alarm_q;
  assign status_o = stat_q;
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsup_pkg::*;
#(
  parameter int unsigned NAUX      = 2,
  parameter int unsigned DB_CYCLES = 8,
  parameter int unsigned HOLD0     = 50,
  parameter int unsigned HOLD1     = 100,
  parameter int unsigned HOLD2     = 200,
  parameter int unsigned HOLD3     = 400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_below_i,
  input  logic [NAUX-1:0] aux_above_i,
  input  logic            mrst_raw_i,
  input  logic [1:0]      hold_sel_i,
  input  logic            arm_we_i,
  input  logic [NAUX-1:0] arm_data_i,
  output logic            sys_rst_o,
  output logic [NAUX-1:0] aux_alarm_o,
  output logic [NAUX-1:0] aux_status_o
);
  localparam int unsigned HOLD_MAXV = max4(HOLD0, HOLD1, HOLD2, HOLD3);
  localparam int unsigned HCW       = $clog2(HOLD_MAXV + 1);

  logic manual_lvl;
  logic fault;

  mrst_debounce #(
    .SYNC_STAGES  (2),
    .STABLE_CYCLES(DB_CYCLES)
  ) u_debounce (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (mrst_raw_i),
    .level_o(manual_lvl)
  );

  assign fault = main_below_i | manual_lvl;

  hold_timer #(
    .HOLD0(HOLD0),
    .HOLD1(HOLD1),
    .HOLD2(HOLD2),
    .HOLD3(HOLD3),
    .CW   (HCW)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault_i (fault),
    .sel_i   (hold_sel_i),
    .active_o(sys_rst_o)
  );

  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    aux_channel u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .above_i  (aux_above_i[g]),
      .arm_we_i (arm_we_i),
      .arm_bit_i(arm_data_i[g]),
      .alarm_o  (aux_alarm_o[g]),
      .status_o (aux_status_o[g])
    );
  end
endmodule

// File: rtl/supsup_chk.sv
module supsup_chk #(
  parameter int unsigned NAUX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            main_below_i,
  input logic [NAUX-1:0] aux_above_i,
  input logic            arm_we_i,
  input logic            sys_rst_o,
  input logic [NAUX-1:0] aux_alarm_o,
  input logic [NAUX-1:0] aux_status_o
);
  AST_BELOW_RAISES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    main_below_i |=> sys_rst_o); // R2

  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> !$past(main_below_i)); // R3

  AST_ALARM_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (aux_alarm_o == $past(aux_above_i))); // R8

  AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((aux_status_o & $past(aux_above_i)) == '0)); // R9

  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_we_i |=> ((aux_status_o & ~$past(aux_status_o)) == '0)); // R10
endmodule

bind supply_supervisor supsup_chk #(.NAUX(NAUX)) u_chk (.*);

// File: tb/supply_supervisor_tb_top.sv
`timescale 1ns/1ps
module supply_supervisor_tb_top;
  localparam int NAUX = 2;
  localparam int DB   = 8;
  localparam int H0 = 50, H1 = 100, H2 = 200, H3 = 400;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            main_below;
  logic [NAUX-1:0] aux_above;
  logic            mr_raw;
  logic [1:0]      sel;
  logic            we;
  logic [NAUX-1:0] wdata;
  logic            sys_rst;
  logic [NAUX-1:0] alarm, status;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string cur_req  = "R1";

  always #5 clk = ~clk;

  supply_supervisor #(
    .NAUX(NAUX), .DB_CYCLES(DB), .HOLD0(H0), .HOLD1(H1), .HOLD2(H2), .HOLD3(H3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .main_below_i(main_below), .aux_above_i(aux_above),
    .mrst_raw_i(mr_raw), .hold_sel_i(sel), .arm_we_i(we), .arm_data_i(wdata),
    .sys_rst_o(sys_rst), .aux_alarm_o(alarm), .aux_status_o(status)
  );

  // Behavioural reference model
  bit              m_sq[$];
  bit              m_db;
  int              m_dbc;
  int              m_left;
  bit              m_rst;
  bit [NAUX-1:0]   m_alarm, m_stat;
  bit              t_s2, t_cond, t_newdb;
  int              t_newdbc;

  function automatic int hold_of(input logic [1:0] s);
    case (s)
      2'b00:   return H0;
      2'b01:   return H1;
      2'b10:   return H2;
      default: return H3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sq = {1'b0, 1'b0};
      m_db = 0; m_dbc = 0; m_left = H3; m_rst = 1;
      m_alarm = '0; m_stat = '0;
    end else begin
      t_s2     = m_sq[0];
      t_cond   = main_below | m_db;
      t_newdb  = m_db;
      t_newdbc = 0;
      if (t_s2 != m_db) begin
        if (m_dbc == DB - 1) t_newdb = t_s2;
        else                 t_newdbc = m_dbc + 1;
      end
      void'(m_sq.pop_front());
      m_sq.push_back(mr_raw);
      m_db  = t_newdb;
      m_dbc = t_newdbc;
      if (t_cond) begin
        m_left = hold_of(sel);
        m_rst  = 1;
      end else if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_rst = 0;
      end
      m_stat  = (we ? wdata : m_stat) & ~aux_above;
      m_alarm = aux_above;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    check(sys_rst === m_rst, cur_req, "sys_rst_o", sys_rst, m_rst);
    check(alarm === m_alarm, "R8", "aux_alarm_o", alarm, m_alarm);
    check(status === m_stat, "R9", "aux_status_o", status, m_stat);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic measure_release(input int exp, input string req);
    int n;
    n = 0;
    do begin
      tick();
      n++;
    end while (sys_rst === 1'b1 && n < 2000);
    check(n == exp, req, "cycles to release", n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; main_below = 0; aux_above = '0; mr_raw = 0;
    sel = 2'b00; we = 0; wdata = '0;
    // R1 reset state
    cur_req = "R1";
    ticks(3);
    check(sys_rst === 1'b1, "R1", "sys_rst_o in reset", sys_rst, 1);
    check(alarm === '0, "R1", "aux_alarm_o in reset", alarm, 0);
    check(status === '0, "R1", "aux_status_o in reset", status, 0);
    rst_n = 1;
    measure_release(H3, "R1");

    // R2 and R3 for each hold select
    for (int s = 0; s < 4; s++) begin
      cur_req = "R2";
      sel = 2'(s);
      main_below = 1;
      tick();
      check(sys_rst === 1'b1, "R2", "rst after dip", sys_rst, 1);
      ticks(4);
      check(sys_rst === 1'b1, "R2", "rst held in dip", sys_rst, 1);
      main_below = 0;
      cur_req = "R3";
      measure_release(hold_of(2'(s)), "R3");
      ticks(3);
    end

    // R4 re-dip during countdown reloads
    cur_req = "R4";
    sel = 2'b00;
    main_below = 1; ticks(2); main_below = 0;
    ticks(30);
    check(sys_rst === 1'b1, "R4", "rst mid countdown", sys_rst, 1);
    main_below = 1; tick(); main_below = 0;
    measure_release(H0, "R4");

    // R5 manual reset forces reset, R7 hold after release
    cur_req = "R5";
    sel = 2'b01;
    mr_raw = 1;
    ticks(DB + 2);
    check(sys_rst === 1'b0, "R5", "rst before debounce done", sys_rst, 0);
    tick();
    check(sys_rst === 1'b1, "R5", "rst after debounce", sys_rst, 1);
    ticks(20);
    cur_req = "R7";
    mr_raw = 0;
    measure_release(DB + 2 + H1, "R7");

    // R6 short pulse ignored
    cur_req = "R6";
    mr_raw = 1; ticks(3); mr_raw = 0;
    ticks(20);
    check(sys_rst === 1'b0, "R6", "rst after short pulse", sys_rst, 0);
    mr_raw = 1; ticks(DB - 1); mr_raw = 0;
    ticks(20);
    check(sys_rst === 1'b0, "R6", "rst after DB-1 pulse", sys_rst, 0);

    // R8, R9, R10 auxiliary channels
    cur_req = "R3";
    we = 1; wdata = 2'b11; tick(); we = 0;
    check(status === 2'b11, "R9", "status armed", status, 3);
    aux_above = 2'b01; tick();
    check(alarm === 2'b01, "R8", "alarm follows", alarm, 1);
    check(status === 2'b10, "R9", "trip clears bit0", status, 2);
    ticks(5);
    aux_above = 2'b00; tick();
    check(alarm === 2'b00, "R8", "alarm drops", alarm, 0);
    check(status === 2'b10, "R10", "status kept", status, 2);
    we = 1; wdata = 2'b11; aux_above = 2'b10; tick();
    we = 0; aux_above = 2'b00;
    check(status === 2'b01, "R9", "trip wins over write", status, 1);
    ticks(10);
    check(status === 2'b01, "R10", "status retained", status, 1);
    we = 1; wdata = 2'b00; tick(); we = 0;
    check(status === 2'b00, "R9", "write zero", status, 0);
    aux_above = 2'b11; tick(); aux_above = 2'b00; ticks(5);
    check(status === 2'b00, "R10", "no self set", status, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule